// File: doc/BRIEF.md
# CCD Readout Region Sequencer

This block paces the readout of an interline CCD with 28 dummy bits at the start of each line. It runs a pixel counter along each line and a line counter through the field. It marks every clock with the region that sample belongs to:
- horizontal dummy bits
- optical-black columns and optical-black rows
- the effective area
- the output window picked by the mode

It also gives a clamp strobe over the rear optical-black columns, a one-clock end-of-line pulse and a one-clock end-of-field pulse. A video front end gates, clamps and crops the sample stream with these flags.

A field starts on a one-clock `sync_i` pulse. The mode and the field parity are captured on that pulse and held for the whole field. An even field begins with one vertical dummy row. The sensor rows follow: a front group of optical-black rows, then the effective rows, then a rear group of optical-black rows. After the last line the block is idle until the next sync.

There are three output windows:

| Mode | Window | Line length |
|------|--------|-------------|
| Standard 4:3 | 711 columns wide | 1144 clocks |
| Wide, 18 MHz | 948 columns wide | 1144 clocks |
| Wide, 5fsc | 942 columns wide | 1137 and 1138 clocks, alternating, for a mean of 1137.5 |

Each window is centred in the 962 effective columns.

Top module: `ccd_region_seq`

## Requirements
- R1: On every line of an active field, clocks 0 to 27 of the line (the first 28) assert `hdummy_o`, and no other clock does.
- R2: On every sensor row, `ob_col_o` is high for the 4 clocks at line positions 28 to 31 and for the 50 clocks at positions 994 to 1043, which is 54 per line. `clamp_o` is high only on positions 994 to 1043, which is 50 per line.
- R3: `eff_o` is high for the 962 positions 32 to 993 on each effective row, and never on any other row.
- R4: `ob_row_o` is high for line positions 28 to 1043 (1016 clocks) on each front or rear optical-black row.
- R5: `field_even_i` = 1 at sync makes line 0 a vertical dummy row, with `vdummy_o` high on every clock of that line and all region flags except `hdummy_o` low. That field has one more line than a field started with `field_even_i` = 0.
- R6: `mode_i` selects the window width: 00 gives 711, 01 gives 948, 10 gives 942, 11 gives 711. The first window position on a line is 32 + (962 − width)/2.
- R7: `win_o` is active on WIN_ROWS consecutive effective rows, starting at effective row WIN_ROW_OFS.
- R8: A line lasts 1144 clocks in modes 00, 01 and 11. In mode 10, lines with an even index (counting from 0 in the field) last 1137 clocks and lines with an odd index last 1138.
- R9: `eol_o` pulses on the last clock of every line. `eof_o` pulses exactly once per field, on the last clock of the last line, together with `eol_o`. After it, every output stays low until the next sync.
- R10: The clock after `sync_i` is line 0, position 0, even during a running field, which is then abandoned.
- R11: Changes on `mode_i` and `field_even_i` after the sync clock have no effect on the field in progress.
- R12: While `rst_n` is low, and after reset until the first sync, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Field start pulse |
| field_even_i | input | 1 | 1: even field with vertical dummy row (sampled at sync) |
| mode_i | input | 2 | Window/line mode (sampled at sync) |
| hdummy_o | output | 1 | Horizontal dummy bit |
| vdummy_o | output | 1 | Vertical dummy row |
| ob_col_o | output | 1 | Optical-black column on a sensor row |
| ob_row_o | output | 1 | Optical-black row, pixel columns |
| eff_o | output | 1 | Effective area |
| win_o | output | 1 | Selected output window |
| clamp_o | output | 1 | Clamp strobe, rear optical-black columns |
| eol_o | output | 1 | Last clock of a line |
| eof_o | output | 1 | Last clock of a field |

## Verification
A wrong pixel count moves the region boundaries, and that shows at once in the per-line flag counts of the same line. A wrong line count or a lost parity bit changes the number of end-of-line pulses before the end-of-field pulse, which is visible when that field closes. A mode register that follows `mode_i` during the field changes the window width on the very next line. A wrong line length, including a broken short/long alternation in mode 10, shows as a wrong number of clocks between two end-of-line pulses.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    MODE_STD    = 2'b00,
    MODE_WIDE18 = 2'b01,
    MODE_WIDE5F = 2'b10,
    MODE_SPARE  = 2'b11
  } seq_mode_e;

  typedef struct packed {
    logic hdummy;
    logic vdummy;
    logic ob_col;
    logic ob_row;
    logic eff;
    logic win;
    logic clamp;
  } region_flags_t;
endpackage

// File: rtl/ccd_hcount.sv
module ccd_hcount #(
  parameter int HCW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           run_i,
  input  logic [HCW-1:0] line_last_i,
  output logic [HCW-1:0] hcnt_o,
  output logic           line_end_o
);
  logic [HCW-1:0] hcnt_q, hcnt_d;

  assign line_end_o = run_i && (hcnt_q == line_last_i);
  assign hcnt_o     = hcnt_q;

  always_comb begin
    hcnt_d = hcnt_q;
    if (start_i)         hcnt_d = '0;
    else if (run_i)      hcnt_d = line_end_o ? '0 : hcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= hcnt_d;
  end
endmodule

// File: rtl/ccd_vcount.sv
module ccd_vcount #(
  parameter int VW          = 10,
  parameter int SENSOR_ROWS = 674
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          extra_row_i,
  input  logic          line_end_i,
  output logic [VW-1:0] vcnt_o,
  output logic          run_o,
  output logic          field_end_o
);
  localparam logic [VW-1:0] LAST_BASE = VW'(SENSOR_ROWS - 1);

  logic [VW-1:0] vcnt_q, vcnt_d;
  logic          run_q, run_d;
  logic          last_line;

  assign last_line   = (vcnt_q == LAST_BASE + VW'(extra_row_i));
  assign field_end_o = line_end_i && last_line;
  assign vcnt_o      = vcnt_q;
  assign run_o       = run_q;

  always_comb begin
    vcnt_d = vcnt_q;
    run_d  = run_q;
    if (start_i) begin
      vcnt_d = '0;
      run_d  = 1'b1;
    end else if (line_end_i) begin
      vcnt_d = field_end_o ? '0 : vcnt_q + 1'b1;
      if (field_end_o) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q <= '0;
      run_q  <= 1'b0;
    end else begin
      vcnt_q <= vcnt_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/ccd_region_decode.sv
module ccd_region_decode
  import ccd_seq_pkg::*;
#(
  parameter int HCW           = 11,
  parameter int VW            = 10,
  parameter int DUMMY_BITS    = 28,
  parameter int OB_FRONT_COLS = 4,
  parameter int EFF_COLS      = 962,
  parameter int OB_REAR_COLS  = 50,
  parameter int OB_FRONT_ROWS = 12,
  parameter int EFF_ROWS      = 654,
  parameter int WIN_ROWS      = 485,
  parameter int WIN_ROW_OFS   = 84,
  parameter int WIN_COLS_STD  = 711,
  parameter int WIN_COLS_W18  = 948,
  parameter int WIN_COLS_W5F  = 942
) (
  input  logic          run_i,
  input  logic          even_i,
  input  seq_mode_e     mode_i,
  input  logic [HCW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  output region_flags_t flags_o
);
  localparam logic [HCW-1:0] C_OBF = HCW'(DUMMY_BITS);
  localparam logic [HCW-1:0] C_EFF = HCW'(DUMMY_BITS + OB_FRONT_COLS);
  localparam logic [HCW-1:0] C_OBR = HCW'(DUMMY_BITS + OB_FRONT_COLS + EFF_COLS);
  localparam logic [HCW-1:0] C_END = HCW'(DUMMY_BITS + OB_FRONT_COLS + EFF_COLS + OB_REAR_COLS);
  localparam int             W_BASE = DUMMY_BITS + OB_FRONT_COLS;
  localparam logic [HCW-1:0] WS_STD = HCW'(W_BASE + (EFF_COLS - WIN_COLS_STD) / 2);
  localparam logic [HCW-1:0] WS_W18 = HCW'(W_BASE + (EFF_COLS - WIN_COLS_W18) / 2);
  localparam logic [HCW-1:0] WS_W5F = HCW'(W_BASE + (EFF_COLS - WIN_COLS_W5F) / 2);
  localparam logic [HCW-1:0] WE_STD = WS_STD + HCW'(WIN_COLS_STD);
  localparam logic [HCW-1:0] WE_W18 = WS_W18 + HCW'(WIN_COLS_W18);
  localparam logic [HCW-1:0] WE_W5F = WS_W5F + HCW'(WIN_COLS_W5F);
  localparam logic [VW-1:0]  R_EFF  = VW'(OB_FRONT_ROWS);
  localparam logic [VW-1:0]  R_OBR  = VW'(OB_FRONT_ROWS + EFF_ROWS);
  localparam logic [VW-1:0]  R_WS   = VW'(OB_FRONT_ROWS + WIN_ROW_OFS);
  localparam logic [VW-1:0]  R_WE   = VW'(OB_FRONT_ROWS + WIN_ROW_OFS + WIN_ROWS);

  logic [VW-1:0]  srow;
  logic [HCW-1:0] ws, we;
  logic           vdum, sens, col_pix, col_eff, col_obr, row_ob, row_eff, row_win;

  assign vdum    = run_i && even_i && (vcnt_i == '0);
  assign sens    = run_i && !vdum;
  assign srow    = vcnt_i - VW'(even_i);
  assign col_pix = (hcnt_i >= C_OBF) && (hcnt_i < C_END);
  assign col_eff = (hcnt_i >= C_EFF) && (hcnt_i < C_OBR);
  assign col_obr = (hcnt_i >= C_OBR) && (hcnt_i < C_END);
  assign row_ob  = (srow < R_EFF) || (srow >= R_OBR);
  assign row_eff = !row_ob;
  assign row_win = (srow >= R_WS) && (srow < R_WE);

  always_comb begin
    unique case (mode_i)
      MODE_WIDE18: begin ws = WS_W18; we = WE_W18; end
      MODE_WIDE5F: begin ws = WS_W5F; we = WE_W5F; end
      default:     begin ws = WS_STD; we = WE_STD; end
    endcase
  end

  always_comb begin
    flags_o.hdummy = run_i && (hcnt_i < C_OBF);
    flags_o.vdummy = vdum;
    flags_o.ob_col = sens && col_pix && !col_eff;
    flags_o.ob_row = sens && row_ob && col_pix;
    flags_o.eff    = sens && row_eff && col_eff;
    flags_o.win    = sens && row_eff && row_win && (hcnt_i >= ws) && (hcnt_i < we);
    flags_o.clamp  = sens && col_obr;
  end
endmodule

// File: rtl/ccd_region_seq.sv
module ccd_region_seq
  import ccd_seq_pkg::*;
#(
  parameter int DUMMY_BITS    = 28,
  parameter int OB_FRONT_COLS = 4,
  parameter int EFF_COLS      = 962,
  parameter int OB_REAR_COLS  = 50,
  parameter int OB_FRONT_ROWS = 12,
  parameter int EFF_ROWS      = 654,
  parameter int OB_REAR_ROWS  = 8,
  parameter int WIN_ROWS      = 485,
  parameter int WIN_ROW_OFS   = (EFF_ROWS - WIN_ROWS) / 2,
  parameter int WIN_COLS_STD  = 711,
  parameter int WIN_COLS_W18  = 948,
  parameter int WIN_COLS_W5F  = 942,
  parameter int LINE_LONG     = 1144,
  parameter int LINE_5F_SHORT = 1137
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic       field_even_i,
  input  logic [1:0] mode_i,
  output logic       hdummy_o,
  output logic       vdummy_o,
  output logic       ob_col_o,
  output logic       ob_row_o,
  output logic       eff_o,
  output logic       win_o,
  output logic       clamp_o,
  output logic       eol_o,
  output logic       eof_o
);
  localparam int SENSOR_ROWS = OB_FRONT_ROWS + EFF_ROWS + OB_REAR_ROWS;
  localparam int HCW         = $clog2(LINE_LONG + 2);
  localparam int VW          = $clog2(SENSOR_ROWS + 2);
  localparam logic [HCW-1:0] LAST_LONG = HCW'(LINE_LONG - 1);
  localparam logic [HCW-1:0] LAST_5F_S = HCW'(LINE_5F_SHORT - 1);

  seq_mode_e      mode_q, mode_d;
  logic           even_q, even_d;
  logic           run, line_end, field_end;
  logic [HCW-1:0] hcnt, line_last;
  logic [VW-1:0]  vcnt;
  region_flags_t  flags;

  // field-start capture of mode and parity
  always_comb begin
    mode_d = mode_q;
    even_d = even_q;
    if (sync_i) begin
      mode_d = seq_mode_e'(mode_i);
      even_d = field_even_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STD;
      even_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      even_q <= even_d;
    end
  end

  // 5fsc lines alternate short/long; other modes use the long line
  assign line_last = (mode_q == MODE_WIDE5F) ? LAST_5F_S + HCW'(vcnt[0]) : LAST_LONG;

  ccd_hcount #(.HCW(HCW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .start_i(sync_i), .run_i(run),
    .line_last_i(line_last), .hcnt_o(hcnt), .line_end_o(line_end)
  );

  ccd_vcount #(.VW(VW), .SENSOR_ROWS(SENSOR_ROWS)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .start_i(sync_i), .extra_row_i(even_q),
    .line_end_i(line_end), .vcnt_o(vcnt), .run_o(run), .field_end_o(field_end)
  );

  ccd_region_decode #(
    .HCW(HCW), .VW(VW), .DUMMY_BITS(DUMMY_BITS), .OB_FRONT_COLS(OB_FRONT_COLS),
    .EFF_COLS(EFF_COLS), .OB_REAR_COLS(OB_REAR_COLS), .OB_FRONT_ROWS(OB_FRONT_ROWS),
    .EFF_ROWS(EFF_ROWS), .WIN_ROWS(WIN_ROWS), .WIN_ROW_OFS(WIN_ROW_OFS),
    .WIN_COLS_STD(WIN_COLS_STD), .WIN_COLS_W18(WIN_COLS_W18), .WIN_COLS_W5F(WIN_COLS_W5F)
  ) u_dec (
    .run_i(run), .even_i(even_q), .mode_i(mode_q), .hcnt_i(hcnt), .vcnt_i(vcnt),
    .flags_o(flags)
  );

  assign hdummy_o = flags.hdummy;
  assign vdummy_o = flags.vdummy;
  assign ob_col_o = flags.ob_col;
  assign ob_row_o = flags.ob_row;
  assign eff_o    = flags.eff;
  assign win_o    = flags.win;
  assign clamp_o  = flags.clamp;
  assign eol_o    = line_end;
  assign eof_o    = field_end;
endmodule

// File: rtl/ccd_region_seq_chk.sv
module ccd_region_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_i,
  input logic [1:0] mode_q,
  input logic       even_q,
  input logic       hdummy_o,
  input logic       vdummy_o,
  input logic       ob_col_o,
  input logic       ob_row_o,
  input logic       eff_o,
  input logic       win_o,
  input logic       clamp_o,
  input logic       eol_o,
  input logic       eof_o
);
  // R1
  col_class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdummy_o, ob_col_o, eff_o}));
  // R2
  clamp_in_ob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |-> ob_col_o);
  // R5
  vdummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vdummy_o |-> !(ob_col_o || ob_row_o || eff_o || clamp_o));
  // R6
  win_in_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> eff_o);
  // R9
  eof_with_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> eol_o);
  // R9
  idle_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_o && !sync_i) |=> !(hdummy_o || eol_o || ob_row_o));
  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> ($stable(mode_q) && $stable(even_q)));
endmodule

bind ccd_region_seq ccd_region_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .mode_q(mode_q), .even_q(even_q),
  .hdummy_o(hdummy_o), .vdummy_o(vdummy_o), .ob_col_o(ob_col_o), .ob_row_o(ob_row_o),
  .eff_o(eff_o), .win_o(win_o), .clamp_o(clamp_o), .eol_o(eol_o), .eof_o(eof_o)
);

// File: tb/ccd_region_seq_test.sv
module ccd_region_seq_test;
  localparam int FR = 2, ER = 8, RR = 2, WR = 4, WOFS = 2;

  logic clk, rst_n, sync_i, field_even_i;
  logic [1:0] mode_i;
  logic hdummy_o, vdummy_o, ob_col_o, ob_row_o, eff_o, win_o, clamp_o, eol_o, eof_o;
  int nchk = 0, nerr = 0, cyc = 0;

  ccd_region_seq #(
    .OB_FRONT_ROWS(FR), .EFF_ROWS(ER), .OB_REAR_ROWS(RR),
    .WIN_ROWS(WR), .WIN_ROW_OFS(WOFS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .field_even_i(field_even_i),
    .mode_i(mode_i), .hdummy_o(hdummy_o), .vdummy_o(vdummy_o), .ob_col_o(ob_col_o),
    .ob_row_o(ob_row_o), .eff_o(eff_o), .win_o(win_o), .clamp_o(clamp_o),
    .eol_o(eol_o), .eof_o(eof_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int any_out();
    return int'({hdummy_o, vdummy_o, ob_col_o, ob_row_o, eff_o, win_o, clamp_o, eol_o, eof_o});
  endfunction

  task automatic start_field(input int md, input bit ev);
    @(negedge clk);
    sync_i = 1'b1; mode_i = md[1:0]; field_even_i = ev;
    @(negedge clk);
    sync_i = 1'b0; mode_i = ~mode_i; field_even_i = !ev; // R11 inputs scrambled after sync
  endtask

  // Runs one field from the current negedge (line 0, position 0) and checks every line.
  task automatic run_field(input int md, input bit ev);
    int li = 0, pos = 0, neof = 0, first_win = -1;
    int c_len = 0, c_hd = 0, c_vd = 0, c_obc = 0, c_obr = 0, c_eff = 0, c_win = 0, c_clp = 0;
    int w = (md == 1) ? 948 : (md == 2) ? 942 : 711;
    bit done = 0;
    while (!done) begin
      c_len++;
      if (hdummy_o) c_hd++;
      if (vdummy_o) c_vd++;
      if (ob_col_o) c_obc++;
      if (ob_row_o) c_obr++;
      if (eff_o)    c_eff++;
      if (clamp_o)  c_clp++;
      if (win_o) begin c_win++; if (first_win < 0) first_win = pos; end
      if (eof_o) neof++;
      pos++;
      if (eol_o) begin
        bit dum = ev && (li == 0);
        int s = li - int'(ev);
        bit rob = !dum && (s < FR || s >= FR + ER);
        bit ref_ = !dum && !rob;
        bit rwin = ref_ && (s - FR >= WOFS) && (s - FR < WOFS + WR);
        int elen = (md == 2) ? ((li % 2 == 1) ? 1138 : 1137) : 1144;
        chk("R8 line length", c_len, elen);
        chk("R1 dummy bits", c_hd, 28);
        chk("R5 vertical dummy row", c_vd, dum ? elen : 0);
        chk("R2 ob columns", c_obc, dum ? 0 : 54);
        chk("R2 clamp", c_clp, dum ? 0 : 50);
        chk("R4 ob rows", c_obr, rob ? 1016 : 0);
        chk("R3 effective", c_eff, ref_ ? 962 : 0);
        chk("R6 R7 window width", c_win, rwin ? w : 0);
        if (rwin) chk("R6 window start", first_win, 32 + (962 - w) / 2);
        li++; pos = 0; first_win = -1;
        c_len = 0; c_hd = 0; c_vd = 0; c_obc = 0; c_obr = 0; c_eff = 0; c_win = 0; c_clp = 0;
        if (eof_o) done = 1;
      end
      @(negedge clk);
    end
    chk("R5 lines per field", li, FR + ER + RR + int'(ev));
    chk("R9 single eof", neof, 1);
    for (int k = 0; k < 20; k++) begin
      chk("R9 idle after field", any_out(), 0);
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; sync_i = 1'b0; field_even_i = 1'b0; mode_i = 2'b00;
    repeat (3) @(negedge clk);
    chk("R12 outputs in reset", any_out(), 0);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R12 idle before sync", any_out(), 0);
    end
  endtask

  task automatic test_mode(input int md, input bit ev);
    start_field(md, ev);
    run_field(md, ev);
  endtask

  task automatic test_restart();
    start_field(0, 1'b0);
    repeat (3000) @(negedge clk);
    start_field(1, 1'b1);
    chk("R10 restart dummy bit", int'(hdummy_o), 1);
    chk("R10 restart row 0", int'(vdummy_o), 1);
    run_field(1, 1'b1);
  endtask

  initial begin
    test_reset();
    test_mode(0, 1'b0);
    test_mode(0, 1'b1);
    test_mode(1, 1'b0);
    test_mode(1, 1'b1);
    test_mode(2, 1'b0);
    test_mode(2, 1'b1);
    test_mode(3, 1'b0);
    test_restart();
    summary();
  end
endmodule